// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides which clock domains of a small microcontroller keep running while the processor sleeps. Software picks one of four sleep modes on a 2-bit select and arms sleep with an enable bit. When the core then raises its sleep strobe, the controller drops a chosen set of clock enables. The domains are the processor clock, the peripheral I/O clock, the converter clock and the main oscillator. A status flag shows that the part is asleep.

A pending enabled interrupt wakes the part. Two modes resume on the next clock edge. The other two keep the processor clock off while the oscillator settles. The settling count is a parameter for the mode that stopped the oscillator and a short fixed count for the mode that kept it running. Every enable comes straight from a flop, so a wake input never reaches a gate without passing a clock edge. Synchronous reset turns every domain back on.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: When `rst` is high at a rising edge, all four enables are 1 and `asleep` is 0 after that edge.
- R2: A `sleep_strobe` sampled while `sleep_en` is 0 leaves every output unchanged.
- R3: A `sleep_strobe` sampled with `sleep_en` at 1 while awake sets `asleep` to 1 and `cpu_clk_en` to 0 at that same edge.
- R4: Mode 2'b00 (idle) keeps `io_clk_en`, `adc_clk_en` and `osc_en` at 1 while asleep.
- R5: Mode 2'b01 (converter quiet) sets `io_clk_en` to 0 and keeps `adc_clk_en` and `osc_en` at 1 while asleep.
- R6: Mode 2'b10 (power-down) sets all four enables to 0 while asleep.
- R7: Mode 2'b11 (standby) keeps only `osc_en` at 1 while asleep.
- R8: In modes 2'b00 and 2'b01, the edge that samples `wake_irq` at 1 sets all enables to 1 and clears `asleep`.
- R9: In mode 2'b10, the edge that samples `wake_irq` at 1 sets `osc_en` to 1. The other three enables return to 1 and `asleep` clears exactly SLOW_START edges after that edge.
- R10: In mode 2'b11, the processor, I/O and converter enables return to 1 and `asleep` clears exactly FAST_START (6) edges after the edge that samples `wake_irq`.
- R11: While asleep or warming up, changes on `mode_sel`, extra strobes and further `wake_irq` pulses have no effect. While awake, `wake_irq` has no effect.
- R12: Outputs change only at rising clock edges. A change on `wake_irq` between edges does not reach any output before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Arms the sleep strobe |
| mode_sel | input | 2 | Sleep mode: 00 idle, 01 converter quiet, 10 power-down, 11 standby |
| sleep_strobe | input | 1 | Sleep instruction executed |
| wake_irq | input | 1 | Pending enabled interrupt |
| cpu_clk_en | output | 1 | Processor clock enable |
| io_clk_en | output | 1 | Peripheral I/O clock enable |
| adc_clk_en | output | 1 | Converter clock enable |
| osc_en | output | 1 | Main oscillator enable |
| asleep | output | 1 | Sleeping status |

## Verification
The bench enters each mode and counts the exact number of edges before the processor clock returns. An off-by-one settling counter would show up as an early or late `cpu_clk_en` rise after power-down or standby. It changes `mode_sel` and pulses strobes and wakes mid-sleep and mid-settling. A design that kept tracking the select would switch gate sets, and one that restarted its count would wake late. It also raises `wake_irq` between edges and looks at the enables before the next edge. A combinational wake path would turn the processor clock on early.

// File: rtl/sleep_gate_pkg.sv
package sleep_gate_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_ADCQ  = 2'b01,
        MODE_PDOWN = 2'b10,
        MODE_STBY  = 2'b11
    } slp_mode_e;

    typedef enum logic [1:0] {
        PH_RUN  = 2'b00,
        PH_DOZE = 2'b01,
        PH_WARM = 2'b10
    } slp_phase_e;

    typedef struct packed {
        logic cpu;
        logic io;
        logic adc;
        logic osc;
    } clk_gates_t;

    localparam clk_gates_t GATES_ALL_ON = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
    localparam clk_gates_t GATES_WARM   = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};

    // Gate set applied while dozing in a given mode
    function automatic clk_gates_t doze_gates(slp_mode_e m);
        clk_gates_t g;
        g.cpu = 1'b0;
        case (m)
            MODE_IDLE:  begin g.io = 1'b1; g.adc = 1'b1; g.osc = 1'b1; end
            MODE_ADCQ:  begin g.io = 1'b0; g.adc = 1'b1; g.osc = 1'b1; end
            MODE_PDOWN: begin g.io = 1'b0; g.adc = 1'b0; g.osc = 1'b0; end
            default:    begin g.io = 1'b0; g.adc = 1'b0; g.osc = 1'b1; end
        endcase
        return g;
    endfunction

    // Modes whose wake must wait for the oscillator count
    function automatic logic needs_settle(slp_mode_e m);
        return (m == MODE_PDOWN) || (m == MODE_STBY);
    endfunction

endpackage

// File: rtl/slp_warm_timer.sv
module slp_warm_timer
    import sleep_gate_pkg::*;
#(
    parameter int SLOW_START = 64,
    parameter int FAST_START = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic slow_sel,
    input  logic tick,
    output logic done
);
    localparam int MAXC  = (SLOW_START > FAST_START) ? SLOW_START : FAST_START;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_START - 1);
    localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_START - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= slow_sel ? SLOW_LD : FAST_LD;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    initial begin
        a_r9_params_ok: assert (SLOW_START >= 1 && FAST_START >= 1);
    end

    // R9/R10: settling counts down by one per edge
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && $past(!rst) && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R10: a fast load starts from the fixed short count
    a_r10_fast_load: assert property (@(posedge clk) disable iff (rst)
        (load && !slow_sel) |=> (cnt_q == FAST_LD));

endmodule

// File: rtl/slp_phase_fsm.sv
module slp_phase_fsm
    import sleep_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_en,
    input  logic [1:0] mode_sel,
    input  logic       sleep_strobe,
    input  logic       wake_irq,
    input  logic       tmr_done,
    output slp_phase_e phase_d,
    output slp_mode_e  mode_d,
    output logic       tmr_load,
    output logic       tmr_slow,
    output logic       tmr_tick
);
    slp_phase_e phase_q;
    slp_mode_e  mode_q;
    logic       fire;

    assign fire   = (phase_q == PH_RUN) && sleep_strobe && sleep_en;
    assign mode_d = fire ? slp_mode_e'(mode_sel) : mode_q;

    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_tick = 1'b0;
        case (phase_q)
            PH_RUN: if (fire) phase_d = PH_DOZE;
            PH_DOZE: begin
                if (wake_irq) begin
                    if (needs_settle(mode_q)) begin
                        phase_d  = PH_WARM;
                        tmr_load = 1'b1;
                    end else begin
                        phase_d = PH_RUN;
                    end
                end
            end
            PH_WARM: begin
                tmr_tick = 1'b1;
                if (tmr_done) phase_d = PH_RUN;
            end
            default: phase_d = PH_RUN;
        endcase
    end

    assign tmr_slow = (mode_q == MODE_PDOWN);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_RUN;
            mode_q  <= MODE_IDLE;
        end else begin
            phase_q <= phase_d;
            mode_q  <= mode_d;
        end
    end

    // R2: an unarmed strobe keeps the part running
    a_r2_unarmed: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && sleep_strobe && !sleep_en) |=> (phase_q == PH_RUN));

    // R11: the latched mode holds while not running
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_RUN) |=> $stable(mode_q));

    // R8: the light modes resume without a settling phase
    a_r8_direct_wake: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DOZE && wake_irq && !needs_settle(mode_q)) |=> (phase_q == PH_RUN));

endmodule

// File: rtl/slp_gate_reg.sv
module slp_gate_reg
    import sleep_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slp_phase_e phase_d,
    input  slp_mode_e  mode_d,
    output clk_gates_t gates_q,
    output logic       asleep_q
);
    clk_gates_t gates_d;

    always_comb begin
        case (phase_d)
            PH_DOZE: gates_d = doze_gates(mode_d);
            PH_WARM: gates_d = GATES_WARM;
            default: gates_d = GATES_ALL_ON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gates_q  <= GATES_ALL_ON;
            asleep_q <= 1'b0;
        end else begin
            gates_q  <= gates_d;
            asleep_q <= (phase_d != PH_RUN);
        end
    end

    logic rst_seen_q;
    always_ff @(posedge clk) rst_seen_q <= rst;

    // R1: one edge after reset everything runs
    always @(posedge clk) begin
        if (rst_seen_q) begin
            a_r1_reset_on: assert (gates_q == GATES_ALL_ON && !asleep_q);
        end
    end

    // R3: the processor clock is never enabled while asleep
    a_r3_cpu_gated: assert property (@(posedge clk) disable iff (rst)
        asleep_q |-> !gates_q.cpu);

    // R6: the oscillator is only stopped during sleep
    a_r6_osc_only_asleep: assert property (@(posedge clk) disable iff (rst)
        !gates_q.osc |-> asleep_q);

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
    import sleep_gate_pkg::*;
#(
    parameter int SLOW_START = 64,
    parameter int FAST_START = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_en,
    input  logic [1:0] mode_sel,
    input  logic       sleep_strobe,
    input  logic       wake_irq,
    output logic       cpu_clk_en,
    output logic       io_clk_en,
    output logic       adc_clk_en,
    output logic       osc_en,
    output logic       asleep
);
    slp_phase_e phase_d;
    slp_mode_e  mode_d;
    logic       tmr_load, tmr_slow, tmr_tick, tmr_done;
    clk_gates_t gates_q;

    slp_phase_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sleep_en     (sleep_en),
        .mode_sel     (mode_sel),
        .sleep_strobe (sleep_strobe),
        .wake_irq     (wake_irq),
        .tmr_done     (tmr_done),
        .phase_d      (phase_d),
        .mode_d       (mode_d),
        .tmr_load     (tmr_load),
        .tmr_slow     (tmr_slow),
        .tmr_tick     (tmr_tick)
    );

    slp_warm_timer #(
        .SLOW_START (SLOW_START),
        .FAST_START (FAST_START)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .slow_sel (tmr_slow),
        .tick     (tmr_tick),
        .done     (tmr_done)
    );

    slp_gate_reg u_gates (
        .clk      (clk),
        .rst      (rst),
        .phase_d  (phase_d),
        .mode_d   (mode_d),
        .gates_q  (gates_q),
        .asleep_q (asleep)
    );

    assign cpu_clk_en = gates_q.cpu;
    assign io_clk_en  = gates_q.io;
    assign adc_clk_en = gates_q.adc;
    assign osc_en     = gates_q.osc;

    // R7: standby keeps the oscillator alive throughout sleep
    a_r7_standby_osc: assert property (@(posedge clk) disable iff (rst)
        (asleep && $past(asleep) && $past(mode_d) == MODE_STBY && mode_d == MODE_STBY) |-> osc_en);

endmodule

// File: tb/sleep_clk_ctrl_test.sv
module sleep_clk_ctrl_test;
    localparam int SLOW = 20;
    localparam int FAST = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_en = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic sleep_strobe = 1'b0;
    logic wake_irq = 1'b0;
    logic cpu_clk_en, io_clk_en, adc_clk_en, osc_en, asleep;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit model_on = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sleep_clk_ctrl #(.SLOW_START(SLOW), .FAST_START(FAST)) uut (
        .clk(clk), .rst(rst), .sleep_en(sleep_en), .mode_sel(mode_sel),
        .sleep_strobe(sleep_strobe), .wake_irq(wake_irq),
        .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .adc_clk_en(adc_clk_en),
        .osc_en(osc_en), .asleep(asleep)
    );

    function automatic logic [4:0] outs();
        return {cpu_clk_en, io_clk_en, adc_clk_en, osc_en, asleep};
    endfunction

    task automatic check(string req, logic [4:0] act, logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b (cpu,io,adc,osc,asleep) t=%0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 awake, 1 sleeping, 2 settling
    int m_ph = 0;
    int m_mode = 0;
    int m_cnt = 0;

    function automatic logic [4:0] model_out();
        if (m_ph == 0) return 5'b11110;
        if (m_ph == 2) return 5'b00011;
        case (m_mode)
            0: return 5'b01111;
            1: return 5'b00111;
            2: return 5'b00001;
            default: return 5'b00011;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0;
            model_on = 1'b1;
        end else begin
            case (m_ph)
                0: if (sleep_strobe && sleep_en) begin m_ph = 1; m_mode = int'(mode_sel); end
                1: if (wake_irq) begin
                       if (m_mode < 2) m_ph = 0;
                       else begin m_ph = 2; m_cnt = (m_mode == 2) ? SLOW : FAST; end
                   end
                default: begin m_cnt--; if (m_cnt == 0) m_ph = 0; end
            endcase
        end
        #2;
        if (model_on && !finished) check(cur_req, outs(), model_out());
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic enter(logic [1:0] m, string req);
        cur_req = req;
        sleep_en = 1'b1; mode_sel = m; sleep_strobe = 1'b1;
        @(negedge clk);
        sleep_strobe = 1'b0; sleep_en = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
    endtask

    // Count edges from the wake edge to the processor clock return
    task automatic timed_wake(int exp_n, string req);
        int n;
        cur_req = req;
        wake_irq = 1'b1;
        @(posedge clk); #1;
        wake_irq = 1'b0;
        check(req, {osc_en, cpu_clk_en}, 2'b10);
        n = 0;
        while (!cpu_clk_en && n < 1000) begin
            @(posedge clk); #1;
            n++;
        end
        n_chk++;
        if (n != exp_n) begin
            n_bad++;
            $display("FAIL %s settle edges actual=%0d expected=%0d", req, n, exp_n);
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        n_bad++; n_chk++;
        $display("FAIL watchdog R1..R12 actual=hung expected=finished");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step(3);
        check("R1", outs(), 5'b11110);
        rst = 1'b0;
        step(2);

        // R2: unarmed strobe
        cur_req = "R2";
        sleep_strobe = 1'b1; mode_sel = 2'b10;
        step(1);
        sleep_strobe = 1'b0;
        step(1);
        check("R2", outs(), 5'b11110);

        // R11: wake while awake is ignored
        cur_req = "R11";
        pulse_wake();
        check("R11", outs(), 5'b11110);

        // R3/R4 idle
        enter(2'b00, "R4");
        check("R3", {cpu_clk_en, asleep}, 2'b01);
        check("R4", outs(), 5'b01111);
        // R12: wake between edges must not reach outputs
        cur_req = "R12";
        wake_irq = 1'b1;
        #1;
        check("R12", outs(), 5'b01111);
        @(negedge clk);
        wake_irq = 1'b0;
        check("R8", outs(), 5'b11110);
        step(2);

        // R5 converter quiet
        enter(2'b01, "R5");
        check("R5", outs(), 5'b00111);
        cur_req = "R11";
        mode_sel = 2'b10; sleep_strobe = 1'b1; sleep_en = 1'b1;
        step(2);
        sleep_strobe = 1'b0; sleep_en = 1'b0;
        check("R11", outs(), 5'b00111);
        cur_req = "R8";
        pulse_wake();
        check("R8", outs(), 5'b11110);
        step(2);

        // R6 power-down and slow settling
        enter(2'b10, "R6");
        check("R6", outs(), 5'b00001);
        step(5);
        check("R6", outs(), 5'b00001);
        timed_wake(SLOW, "R9");
        check("R9", outs(), 5'b11110);
        step(2);

        // R7 standby and fast settling
        enter(2'b11, "R7");
        check("R7", outs(), 5'b00011);
        timed_wake(FAST, "R10");
        step(2);

        // R11: disturbances during settling
        enter(2'b10, "R11");
        cur_req = "R11";
        pulse_wake();
        mode_sel = 2'b00; sleep_en = 1'b1; sleep_strobe = 1'b1;
        step(3);
        sleep_strobe = 1'b0; sleep_en = 1'b0;
        pulse_wake();
        check("R11", outs(), 5'b00011);
        step(SLOW);
        check("R11", outs(), 5'b11110);

        // R1: reset during sleep
        enter(2'b10, "R1");
        cur_req = "R1";
        rst = 1'b1;
        step(1);
        check("R1", outs(), 5'b11110);
        rst = 1'b0;
        step(3);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule